// File: doc/BRIEF.md
# SD Command Channel Engine

This block handles the command half of an SD/MMC host. Software programs it through a small word-addressed register port. It writes an argument word and then a command word, and the block serializes a 48-bit command token onto the command line. It then optionally collects a 48-bit or 136-bit reply from the card. The outcome is posted in a status word whose flags software clears by writing ones to a separate clear word. A self-clearing soft reset aborts any transaction in flight and returns the registers to their idle values.

The engine has no streaming interface. The register port has no back-pressure: every write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` is a combinational view of the word selected by `reg_addr`. The command line moves one bit per `sd_tick` pulse. `sd_tick` marks the falling edge of the SD clock, which an external clock generator produces. Card-detect and write-protect pins are reflected as level bits.

Register words, by `reg_addr`: 0 argument (read/write), 1 command (read/write), 2 status (read-only), 3 clear (write-only, reads 0), 4 to 7 response words 0 to 3.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The token is sent most significant bit first, one bit per `sd_tick`, as {0, 1, index[5:0], argument[31:0], CRC7, 1}. CRC7 uses the polynomial x^7+x^3+1 over the first 40 bits, so index 0 with argument 0 ends in byte 0x95. `cmd_oe` is high only while the token's bits are driven, and when the line is idle `cmd_out` is 1 and `cmd_oe` is 0.
- R2: Command word fields: [5:0] index, [6] need-response, [7] long-response, [8] application marker, [9] enable, [10] soft reset. A write with bit 9 set while idle starts a token that carries the most recently written argument. Any command write while bit 9 reads 1 is ignored.
- R3: With bits 6 and 7 both clear, status bit 3 (command sent) sets one tick after the token's last bit, and bit 9 of the command word clears.
- R4: With bit 6 or bit 7 set, each transaction sets exactly one of status bit 0 (response CRC good) and status bit 1 (response error).
- R5: The response is awaited for 64 ticks after the token. If all 64 samples are high, status bits 1 and 2 (timeout) set. A start bit on the 64th sample is still accepted.
- R6: A short reply stores its 32 content bits (frame bits 39:8) in response word 0.
- R7: A long reply stores frame bits 127:0 across response words 3 (most significant) down to 0. Its CRC covers only frame bits 127:8, so the six header bits 133:128 do not affect the outcome.
- R8: A CRC mismatch or an end bit of 0 sets status bit 1 without bit 0 or bit 2.
- R9: Writing 1 to a bit of the clear word clears that status bit, and writing 0 leaves it unchanged. A flag that is set in the same cycle wins over the clear.
- R10: Writing bit 10 of the command word aborts any transaction and zeroes the argument, command, status flags and response words. Bit 10 reads 1 for exactly RST_CYCLES clock cycles and then reads 0. Register writes are ignored while bit 10 reads 1.
- R11: Status bit 4 follows `card_detect_i` and status bit 5 follows `write_prot_i`.
- R12: Bit 9 of the command word reads 1 from the start of a transaction until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick | input | 1 | One-cycle pulse per SD clock falling edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from card |
| card_detect_i | input | 1 | Card-detect pin level |
| write_prot_i | input | 1 | Write-protect pin level |

## Verification
The bench sweeps indices and arguments and compares each captured token against a CRC computed by polynomial division, including the fixed 0x95 closing byte of index 0. A design with a shifted tap or the wrong bit order would fail every token. It places the reply start bit on the 1st and on the 64th sampled tick and also sends no reply at all. An off-by-one timeout counter would either reject the late reply or accept the silent line. Long replies are sent with a corrupted header and with a corrupted payload bit: a CRC window that covers the header would reject the first, and one that is too short would accept the second. The clear word is exercised with zero writes and single-bit writes, and the soft reset pulse width is counted in cycles, so that a clear that touches the wrong bits or a reset that lasts too long or too short is reported.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;
  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_RSP0 = 3'd4;
  localparam logic [2:0] A_RSP1 = 3'd5;
  localparam logic [2:0] A_RSP2 = 3'd6;
  localparam logic [2:0] A_RSP3 = 3'd7;

  localparam int C_NEED = 6;
  localparam int C_LONG = 7;
  localparam int C_EN   = 9;
  localparam int C_SRST = 10;

  localparam int S_OK   = 0;
  localparam int S_ERR  = 1;
  localparam int S_TMO  = 2;
  localparam int S_SENT = 3;

  // one serial step of the x^7+x^3+1 checksum
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_cmd_pkg::*;
#(
  parameter int TOKEN_W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        tick,
  input  logic        start,
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        busy,
  output logic        done
);
  localparam int HDR_W = TOKEN_W - 8;
  localparam int CW    = $clog2(TOKEN_W + 1);

  logic [HDR_W-1:0]   head;
  logic [6:0]         head_crc;
  logic [TOKEN_W-1:0] sh;
  logic [CW-1:0]      cnt;

  assign head = {1'b0, 1'b1, idx_i, arg_i};

  always_comb begin
    head_crc = 7'h00;
    for (int i = HDR_W - 1; i >= 0; i--) head_crc = crc7_step(head_crc, head[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0;
    end else if (abort) begin
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh   <= {head, head_crc, 1'b1};
        cnt  <= CW'(TOKEN_W);
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (cnt != '0) begin
          cmd_out <= sh[TOKEN_W-1];
          cmd_oe  <= 1'b1;
          sh      <= {sh[TOKEN_W-2:0], 1'b1};
          cnt     <= cnt - 1'b1;
        end else begin
          cmd_out <= 1'b1;
          cmd_oe  <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // R1: line is driven only while a token is in flight
  p_oe_in_token_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);
  // R1: idle line rests high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);
endmodule

// File: rtl/sdc_cmd_rx.sv
module sdc_cmd_rx
  import sdc_cmd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64,
  parameter int SHORT_W       = 48,
  parameter int LONG_W        = 136
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               tick,
  input  logic               start,
  input  logic               long_i,
  input  logic               cmd_in,
  output logic               busy,
  output logic               done,
  output logic               ok,
  output logic               err,
  output logic               tmo,
  output logic [LONG_W-9:0]  data
);
  localparam int DW     = LONG_W - 8;
  localparam int PW     = $clog2(LONG_W);
  localparam int WW     = $clog2(TIMEOUT_TICKS);
  localparam int S_LAST = SHORT_W - 1;
  localparam int S_HI   = SHORT_W - 9;
  localparam int L_LAST = LONG_W - 1;
  localparam int L_LO   = LONG_W - DW;
  localparam int L_HI   = LONG_W - 9;

  typedef enum logic [1:0] {R_IDLE, R_WAIT, R_RECV} rx_state_e;

  rx_state_e      st;
  logic [DW-1:0]  sh;
  logic [6:0]     crc;
  logic [PW-1:0]  pos;
  logic [WW-1:0]  wcnt;
  logic           lng;
  logic [PW-1:0]  lo, hi, last;

  assign lo   = lng ? PW'(L_LO)   : PW'(1);
  assign hi   = lng ? PW'(L_HI)   : PW'(S_HI);
  assign last = lng ? PW'(L_LAST) : PW'(S_LAST);
  assign busy = (st != R_IDLE);
  assign data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; sh <= '0; crc <= '0; pos <= '0; wcnt <= '0; lng <= 1'b0;
      done <= 1'b0; ok <= 1'b0; err <= 1'b0; tmo <= 1'b0;
    end else if (abort) begin
      st <= R_IDLE; done <= 1'b0; ok <= 1'b0; err <= 1'b0; tmo <= 1'b0;
    end else begin
      done <= 1'b0; ok <= 1'b0; err <= 1'b0; tmo <= 1'b0;
      unique case (st)
        R_IDLE: if (start) begin
          st <= R_WAIT; sh <= '0; crc <= '0; wcnt <= '0; lng <= long_i;
        end
        R_WAIT: if (tick) begin
          if (!cmd_in) begin
            st  <= R_RECV;
            pos <= PW'(1);
          end else if (wcnt == WW'(TIMEOUT_TICKS - 1)) begin
            st <= R_IDLE; done <= 1'b1; err <= 1'b1; tmo <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        R_RECV: if (tick) begin
          sh  <= {sh[DW-2:0], cmd_in};
          pos <= pos + 1'b1;
          if (pos >= lo && pos <= hi) crc <= crc7_step(crc, cmd_in);
          if (pos == last) begin
            st   <= R_IDLE;
            done <= 1'b1;
            if ((crc == sh[6:0]) && cmd_in) ok <= 1'b1;
            else err <= 1'b1;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R4: a finished reply reports exactly one verdict
  p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != err));
  // R5: a timeout is always an error and ends the reply phase
  p_timeout_is_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (err && done && !busy));
  // R4: no verdict without a finished reply
  p_no_stray_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || err) |-> done);
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_cmd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64,
  parameter int RST_CYCLES    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sd_tick,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        card_detect_i,
  input  logic        write_prot_i
);
  localparam int TOKEN_W = 48;
  localparam int LONG_W  = 136;
  localparam int RW      = $clog2(RST_CYCLES + 1);
  localparam int NRSP    = 4;

  logic [31:0]    arg_q;
  logic [9:0]     cmd_q;
  logic [3:0]     sts_q;
  logic [31:0]    rsp_q [NRSP];
  logic [RW-1:0]  rst_cnt;

  logic rst_active, wr_cmd, soft_req, start, abort, need_q, fin;
  logic tx_busy, tx_done;
  logic rx_busy, rx_done, rx_ok, rx_err, rx_tmo;
  logic [LONG_W-9:0] rx_data;
  logic [3:0] clr_mask, set_mask;

  assign rst_active = (rst_cnt != '0);
  assign wr_cmd     = reg_we && (reg_addr == A_CMD) && !rst_active;
  assign soft_req   = wr_cmd && reg_wdata[C_SRST];
  assign start      = wr_cmd && reg_wdata[C_EN] && !reg_wdata[C_SRST] && !cmd_q[C_EN];
  assign abort      = soft_req || rst_active;
  assign need_q     = cmd_q[C_NEED] || cmd_q[C_LONG];
  assign fin        = (tx_done && !need_q) || rx_done;
  assign clr_mask   = (reg_we && (reg_addr == A_CLR) && !rst_active) ? reg_wdata[3:0] : 4'h0;
  assign set_mask   = {tx_done && !need_q, rx_tmo, rx_err, rx_ok};

  sdc_cmd_tx #(.TOKEN_W(TOKEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort(abort), .tick(sd_tick), .start(start),
    .idx_i(reg_wdata[5:0]), .arg_i(arg_q),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(tx_busy), .done(tx_done)
  );

  sdc_cmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .SHORT_W(TOKEN_W), .LONG_W(LONG_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort(abort), .tick(sd_tick),
    .start(tx_done && need_q), .long_i(cmd_q[C_LONG]), .cmd_in(cmd_in),
    .busy(rx_busy), .done(rx_done), .ok(rx_ok), .err(rx_err), .tmo(rx_tmo),
    .data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0; cmd_q <= '0; sts_q <= '0; rst_cnt <= '0;
      for (int i = 0; i < NRSP; i++) rsp_q[i] <= '0;
    end else if (soft_req) begin
      arg_q <= '0; cmd_q <= '0; sts_q <= '0; rst_cnt <= RW'(RST_CYCLES);
      for (int i = 0; i < NRSP; i++) rsp_q[i] <= '0;
    end else begin
      if (rst_active) rst_cnt <= rst_cnt - 1'b1;
      if (reg_we && (reg_addr == A_ARG) && !rst_active) arg_q <= reg_wdata;
      if (wr_cmd && !cmd_q[C_EN]) cmd_q <= reg_wdata[9:0];
      if (fin) cmd_q[C_EN] <= 1'b0;
      sts_q <= (sts_q & ~clr_mask) | set_mask;
      if (rx_done && !rx_tmo) begin
        if (cmd_q[C_LONG]) begin
          for (int i = 0; i < NRSP; i++) rsp_q[i] <= rx_data[32*i +: 32];
        end else begin
          rsp_q[0] <= rx_data[39:8];
        end
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_ARG:   reg_rdata = arg_q;
      A_CMD:   reg_rdata = {21'h0, rst_active, cmd_q};
      A_STAT:  reg_rdata = {26'h0, write_prot_i, card_detect_i, sts_q};
      A_RSP0:  reg_rdata = rsp_q[0];
      A_RSP1:  reg_rdata = rsp_q[1];
      A_RSP2:  reg_rdata = rsp_q[2];
      A_RSP3:  reg_rdata = rsp_q[3];
      default: reg_rdata = 32'h0;
    endcase
  end

  // R2: a token never starts on top of a running one
  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!tx_busy && !rx_busy));
  // R12: enable reads 1 whenever either half is active
  p_enable_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy || rx_busy) |-> cmd_q[C_EN]);
  // R9: a one in the clear word removes the flag unless it is set again
  p_clear_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR && reg_wdata[S_OK] && !rx_ok && !rst_active) |=> !sts_q[S_OK]);
  // R9: a zero in the clear word keeps the flag
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR && !reg_wdata[S_OK] && sts_q[S_OK] && !soft_req) |=> sts_q[S_OK]);
  // R10: the line stays released during soft reset
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_active && $past(rst_active)) |-> !cmd_oe);
endmodule

// File: tb/sdc_cmd_engine_bench.sv
module sdc_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 8;

  logic clk = 1'b0, rst_n = 1'b0, sd_tick = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic cmd_out, cmd_oe, cmd_in = 1'b1, card_detect_i = 1'b0, write_prot_i = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  sdc_cmd_engine #(.TIMEOUT_TICKS(64), .RST_CYCLES(RST_CYC)) u_sdc_cmd_engine (
    .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .card_detect_i(card_detect_i), .write_prot_i(write_prot_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit cond, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // remainder of m * x^7 divided by x^7+x^3+1 (0x89)
  function automatic logic [6:0] bcrc(input logic [127:0] m, input int n);
    logic [134:0] v;
    v = 135'(m) << 7;
    for (int i = n + 6; i >= 7; i--) if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  function automatic logic [47:0] tok(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, bcrc(128'({2'b01, idx, arg}), 40), 1'b1};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sd_tick = 1'b1;
    @(negedge clk); sd_tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cmdw(input logic [5:0] idx, input bit need, input bit lng);
    return {22'h0, 1'b1, 1'b0, lng, need, idx};
  endfunction

  // starts a command and captures its token; one extra tick ends the token
  task automatic run_token(input logic [5:0] idx, input bit need, input bit lng,
                           output logic [47:0] cap, output bit oe_all);
    wr(3'd1, cmdw(idx, need, lng));
    cmd_in = 1'b1; oe_all = 1'b1;
    for (int k = 0; k < 48; k++) begin
      tick(); cap[47-k] = cmd_out; if (!cmd_oe) oe_all = 1'b0;
    end
    tick();
  endtask

  task automatic send(input logic [135:0] f, input int n, input int delay);
    cmd_in = 1'b1;
    for (int k = 0; k < delay; k++) tick();
    for (int i = n - 1; i >= 0; i--) begin cmd_in = f[i]; tick(); end
    cmd_in = 1'b1;
  endtask

  function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] c, input bit bad_crc, input bit end_bit);
    logic [6:0] k;
    k = bcrc(128'({2'b00, idx, c}), 40) ^ (bad_crc ? 7'h10 : 7'h00);
    return 136'({2'b00, idx, c, k, end_bit});
  endfunction

  function automatic logic [135:0] long_frame(input logic [5:0] hdr, input logic [119:0] c);
    return {2'b00, hdr, c, bcrc(128'(c), 120), 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [47:0] cap;
    bit oe_all;
    logic [135:0] lf;
    int cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle line after reset
    chk(cmd_out === 1'b1 && cmd_oe === 1'b0, "R1 idle line", {cmd_out, cmd_oe}, 2'b10);
    rd(3'd2, v); chk(v == 32'h0, "R11 reset status", v, 0);
    rd(3'd1, v); chk(v == 32'h0, "R2 reset command word", v, 0);

    // R11: pin levels
    for (int p = 0; p < 4; p++) begin
      card_detect_i = p[0]; write_prot_i = p[1];
      rd(3'd2, v); chk(v[5:4] == 2'(p), "R11 pin levels", v[5:4], p);
    end
    card_detect_i = 1'b0; write_prot_i = 1'b0;

    // R1: known vector, index 0 argument 0 ends in 0x95
    chk(bcrc(128'({2'b01, 6'd0, 32'd0}), 40) == 7'h4A, "R1 bench crc sanity", 0, 7'h4A);
    wr(3'd0, 32'h0);
    run_token(6'd0, 1'b0, 1'b0, cap, oe_all);
    chk(cap[7:0] == 8'h95, "R1 index0 closing byte", cap[7:0], 8'h95);
    chk(oe_all, "R1 oe during token", oe_all, 1);
    chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1 released after token", {cmd_out, cmd_oe}, 2'b10);
    rd(3'd2, v); chk(v[3:0] == 4'b1000, "R3 command sent flag", v[3:0], 4'b1000);
    rd(3'd1, v); chk(v[9] == 1'b0, "R3 enable self clears", v[9], 0);
    wr(3'd3, 32'hF);

    // R1 R2 R3: sweep of indices and arguments, argument written twice
    for (int j = 0; j < 8; j++) begin
      logic [5:0] ix;
      logic [31:0] ag;
      ix = 6'((j * 9 + 4) % 64);
      ag = 32'h9E37_79B9 * (j + 1) ^ (32'h1 << (j * 4));
      wr(3'd0, ~ag);
      wr(3'd0, ag);
      run_token(ix, 1'b0, 1'b0, cap, oe_all);
      chk(cap == tok(ix, ag) && oe_all, "R1 R2 token sweep", cap, tok(ix, ag));
      rd(3'd2, v); chk(v[3:0] == 4'b1000, "R3 sent after sweep token", v[3:0], 4'b1000);
      wr(3'd3, 32'hF);
    end

    // R12 + R2: enable reads 1 mid-token, and a command write while busy is ignored
    wr(3'd0, 32'hCAFE_0001);
    wr(3'd1, cmdw(6'd5, 1'b0, 1'b0));
    for (int k = 0; k < 10; k++) tick();
    rd(3'd1, v); chk(v[9] == 1'b1, "R12 enable while busy", v[9], 1);
    wr(3'd1, cmdw(6'd9, 1'b1, 1'b1));
    for (int k = 0; k < 39; k++) tick();
    rd(3'd1, v); chk(v[9:0] == 10'h005, "R2 busy write ignored", v[9:0], 10'h005);
    rd(3'd2, v); chk(v[3:0] == 4'b1000, "R2 busy write kept no-reply mode", v[3:0], 4'b1000);
    wr(3'd3, 32'hF);

    // R4 R5 R6: short replies, delay 0 to 63 extra idle samples
    for (int j = 0; j < 4; j++) begin
      int dl;
      logic [31:0] c;
      dl = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 30 : 63;
      c = 32'h1234_5678 + 32'h0101_0101 * j;
      wr(3'd0, 32'h100 + j);
      run_token(6'd17, 1'b1, 1'b0, cap, oe_all);
      rd(3'd1, v); chk(v[9] == 1'b1, "R12 enable while awaiting reply", v[9], 1);
      send(short_frame(6'd17, c, 1'b0, 1'b1), 48, dl);
      rd(3'd2, v); chk(v[3:0] == 4'b0001, "R4 R5 short reply verdict", v[3:0], 4'b0001);
      rd(3'd4, v); chk(v == c, "R6 short content", v, c);
      rd(3'd1, v); chk(v[9] == 1'b0, "R12 enable clears after reply", v[9], 0);
      wr(3'd3, 32'hF);
    end

    // R5: silent line for 64 samples
    run_token(6'd2, 1'b1, 1'b0, cap, oe_all);
    cmd_in = 1'b1;
    for (int k = 0; k < 63; k++) tick();
    rd(3'd2, v); chk(v[3:0] == 4'b0000, "R5 no verdict before 64 samples", v[3:0], 0);
    tick();
    rd(3'd2, v); chk(v[3:0] == 4'b0110, "R5 timeout flags", v[3:0], 4'b0110);
    rd(3'd4, v); chk(v == 32'h1234_5678 + 32'h0303_0303, "R5 timeout keeps response", v, 32'h1537_597B);
    wr(3'd3, 32'hF);

    // R8: bad crc, then bad end bit
    run_token(6'd13, 1'b1, 1'b0, cap, oe_all);
    send(short_frame(6'd13, 32'hDEAD_BEEF, 1'b1, 1'b1), 48, 2);
    rd(3'd2, v); chk(v[3:0] == 4'b0010, "R8 crc mismatch", v[3:0], 4'b0010);
    wr(3'd3, 32'hF);
    run_token(6'd13, 1'b1, 1'b0, cap, oe_all);
    send(short_frame(6'd13, 32'hDEAD_BEEF, 1'b0, 1'b0), 48, 2);
    rd(3'd2, v); chk(v[3:0] == 4'b0010, "R8 end bit zero", v[3:0], 4'b0010);
    wr(3'd3, 32'hF);

    // R7: long replies, word order, header outside the crc, payload inside
    for (int j = 0; j < 3; j++) begin
      logic [119:0] c;
      c = {30{4'(j + 3)}} ^ 120'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1;
      lf = long_frame((j == 1) ? 6'h00 : 6'h3F, c);
      if (j == 2) lf[60] = ~lf[60];
      run_token(6'd2, 1'b0, 1'b1, cap, oe_all);
      send(lf, 136, 5);
      rd(3'd2, v);
      if (j == 2) chk(v[3:0] == 4'b0010, "R7 payload corruption caught", v[3:0], 4'b0010);
      else chk(v[3:0] == 4'b0001, "R7 header not in crc", v[3:0], 4'b0001);
      rd(3'd7, v); chk(v == lf[127:96], "R7 response word 3", v, lf[127:96]);
      rd(3'd6, v); chk(v == lf[95:64], "R7 response word 2", v, lf[95:64]);
      rd(3'd5, v); chk(v == lf[63:32], "R7 response word 1", v, lf[63:32]);
      rd(3'd4, v); chk(v == lf[31:0], "R7 response word 0", v, lf[31:0]);
      wr(3'd3, 32'hF);
    end

    // R9: write-one-to-clear
    run_token(6'd7, 1'b0, 1'b0, cap, oe_all);
    run_token(6'd8, 1'b1, 1'b0, cap, oe_all);
    send(short_frame(6'd8, 32'h55AA_33CC, 1'b0, 1'b1), 48, 0);
    rd(3'd2, v); chk(v[3:0] == 4'b1001, "R9 flags accumulate", v[3:0], 4'b1001);
    wr(3'd3, 32'h0);
    rd(3'd2, v); chk(v[3:0] == 4'b1001, "R9 zero write keeps", v[3:0], 4'b1001);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk(v[3:0] == 4'b1000, "R9 single bit clear", v[3:0], 4'b1000);
    wr(3'd3, 32'h8);
    rd(3'd2, v); chk(v[3:0] == 4'b0000, "R9 last flag clear", v[3:0], 0);

    // R10: soft reset mid-token
    wr(3'd0, 32'h7777_0000);
    wr(3'd1, cmdw(6'd40, 1'b1, 1'b0));
    for (int k = 0; k < 10; k++) tick();
    wr(3'd1, 32'h400);
    reg_addr = 3'd1; cnt = 0;
    #1;
    while (reg_rdata[10] && cnt < 100) begin
      cnt++; @(negedge clk); #1;
    end
    chk(cnt == RST_CYC, "R10 reset pulse width", cnt, RST_CYC);
    rd(3'd1, v); chk(v == 32'h0, "R10 command word cleared", v, 0);
    rd(3'd0, v); chk(v == 32'h0, "R10 argument cleared", v, 0);
    rd(3'd4, v); chk(v == 32'h0, "R10 response cleared", v, 0);
    chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R10 line released", {cmd_out, cmd_oe}, 2'b10);
    for (int k = 0; k < 80; k++) tick();
    rd(3'd2, v); chk(v[3:0] == 4'b0000, "R10 aborted command posts nothing", v[3:0], 0);
    wr(3'd0, 32'h0BAD_F00D);
    run_token(6'd63, 1'b0, 1'b0, cap, oe_all);
    chk(cap == tok(6'd63, 32'h0BAD_F00D), "R10 works after reset", cap, tok(6'd63, 32'h0BAD_F00D));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule